// File: doc/BRIEF.md
# Channel-List Scan Sequencer

This block steps a multiplexed converter front end through a programmed list of input slots. A host writes up to sixteen list entries through a small register port. Each entry holds an input select, a gain code and a polarity flag for one slot. A control word sets the first slot of a scan and the number of slots it covers. Each pacing pulse starts one conversion. The block drives the select, gain and polarity of the current slot to the converter. Each result the converter returns goes into a sample FIFO, and the block raises end-of-conversion and end-of-scan events. Both events are latched as flags and can raise an interrupt.

The host port has a 2-bit word address. At address 0 a write loads the control word and a read pops the FIFO. At address 1 a write loads the mode word and a read returns the status word. At address 2 a write stores a list entry. At address 3 a read empties the FIFO and returns zero. Address 2 and address 3 read as zero, and a write to address 3 has no effect.

The controller has four states:
- IDLE: stopped.
- ARMED: waiting for the external start input.
- WAIT_PACE: ready for a pacing pulse.
- CONVERT: waiting for the converter to finish.

The transitions are:
- start-run: a nonzero control write moves any state to WAIT_PACE, or to ARMED when the arm bit is set.
- stop: a zero control write moves any state to IDLE.
- ext-go: ARMED moves to WAIT_PACE when the external start input is high.
- pace: WAIT_PACE moves to CONVERT on a pacing pulse.
- done: CONVERT moves back to WAIT_PACE when the converter finishes.

Top module: `scan_sequencer`

## Requirements
- R1: A write to address 2 stores an entry into slot bits 11:8, with unipolar flag bit 7, gain code bits 5:4 and input select bits 3:0. The entry of the current slot drives cnv_sel_o, cnv_gain_o and cnv_unipolar_o, and reset clears all entries to zero.
- R2: A write to address 0 sets the scan length minus one from bits 11:8 and the start slot from bits 3:0. With scanning enabled, the slots used are start, start+1, and so on up to start+length-1, counted modulo 16. After the last slot the sequence goes back to the start slot.
- R3: Mode bit 3 enables multi-slot scanning. With it clear, every conversion uses the start slot and every conversion counts as a complete scan.
- R4: cnv_start_o is high for one cycle when pace_i is high in WAIT_PACE and the same cycle carries no control write. pace_i has no effect in IDLE, ARMED or CONVERT.
- R5: If bit 15 of the control write is set, the block enters ARMED. Pacing pulses are then ignored until ext_start_i is seen high.
- R6: A control write of all zeros moves the block to IDLE and returns the slot position to the start slot. A converter completion that arrives after the stop stores nothing and raises no event.
- R7: A converter completion in CONVERT pushes cnv_data_i into the FIFO. A read of address 0 pops the oldest sample, and reads 0 when the FIFO is empty. A result that arrives while the FIFO is full is dropped.
- R8: eos_o is high for exactly the one cycle after the last slot of a scan has completed and its result has been written.
- R9: The status word at address 1 has these fields:
  - bit 15: 1 while a conversion is in progress, 0 once it has finished.
  - bit 14: the latched end-of-conversion flag.
  - bit 13: the latched end-of-scan flag.
  - bit 2: FIFO full.
  - bit 1: FIFO empty.
  - all other bits: 0.
  A status read clears both flags, unless a new event arrives in that same cycle.
- R10: irq_o is (end-of-conversion flag AND mode bit 0) OR (end-of-scan flag AND mode bit 1).
- R11: A read of address 3 empties the FIFO and returns 0. If a result arrives in the same cycle, it is lost.
- R12: After reset the block is in IDLE with an empty FIFO, clear flags, and zero control and mode words. The status word reads 16'h0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Host write strobe |
| bus_rd_i | input | 1 | Host read strobe (side effects at the clock edge) |
| bus_addr_i | input | 2 | Host word address |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Host read data (combinational from the address) |
| pace_i | input | 1 | Pacing pulse that starts one conversion |
| ext_start_i | input | 1 | External start that releases ARMED |
| cnv_start_o | output | 1 | One-cycle converter start |
| cnv_sel_o | output | 4 | Input select of the current slot |
| cnv_gain_o | output | 2 | Gain code of the current slot |
| cnv_unipolar_o | output | 1 | Polarity flag of the current slot |
| cnv_done_i | input | 1 | One-cycle converter completion |
| cnv_data_i | input | 16 | Converter result, valid with cnv_done_i |
| eos_o | output | 1 | End-of-scan pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- The converter answers each start with exactly one cnv_done_i pulse.
- The converter raises cnv_done_i only after a start.
- The host never reads and writes in the same cycle.

The stimulus respects these assumptions:
- Read and write strobes are driven from separate single-cycle tasks.
- The converter model in the bench produces its completion a fixed three cycles after a start.
- After aborting a conversion, the bench waits until the stale completion has come and gone before issuing another pacing pulse.
- Extra pacing pulses are placed only inside conversions, where the design must ignore them.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
    localparam int SLOT_COUNT   = 16;
    localparam int SLOT_W       = $clog2(SLOT_COUNT);
    localparam int CTRL_ARM_BIT = 15;
    localparam int CTRL_LEN_LSB = 8;
    localparam int MODE_SCAN    = 3;
    localparam int MODE_EOS_IE  = 1;
    localparam int MODE_EOC_IE  = 0;

    localparam logic [1:0] ADDR_DATA_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT_MODE = 2'd1;
    localparam logic [1:0] ADDR_ENTRY     = 2'd2;
    localparam logic [1:0] ADDR_FLUSH     = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_WAIT_PACE,
        ST_CONVERT
    } seq_state_e;

    typedef struct packed {
        logic       unipolar;
        logic [1:0] gain;
        logic [3:0] sel;
    } slot_entry_t;
endpackage

// File: rtl/scan_chanlist.sv
module scan_chanlist
    import scan_seq_pkg::*;
#(
    parameter int SLOTS = SLOT_COUNT,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  slot_entry_t wr_entry_i,
    input  logic [IW-1:0] rd_idx_i,
    output slot_entry_t rd_entry_o
);
    slot_entry_t table_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                table_q[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == IW'(g))) begin
                table_q[g] <= wr_entry_i;
            end
        end
    end

    assign rd_entry_o = table_q[rd_idx_i];
endmodule

// File: rtl/scan_fifo.sv
module scan_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             flush_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             full_o,
    output logic             empty_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && !empty_o && !flush_i;
    assign dout_o  = mem_q[rd_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[wr_q] <= din_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(DEPTH));
    a_r7_full_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && push_i && !pop_i && !flush_i) |=> full_o && $stable(wr_q));
    a_r11_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> empty_o);
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
    import scan_seq_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              scan_en_i,
    input  logic              pace_i,
    input  logic              ext_start_i,
    input  logic              cnv_done_i,
    output seq_state_e        state_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              cnv_start_o,
    output logic              done_accept_o,
    output logic              scan_last_o
);
    seq_state_e        state_q, state_nx;
    logic [SLOT_W-1:0] start_q, len_q, pos_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_nx;
    end

    // next state: host control write overrides every transition
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:      state_nx = ST_IDLE;
            ST_ARMED:     if (ext_start_i) state_nx = ST_WAIT_PACE;
            ST_WAIT_PACE: if (pace_i)      state_nx = ST_CONVERT;
            ST_CONVERT:   if (cnv_done_i)  state_nx = ST_WAIT_PACE;
            default:      state_nx = ST_IDLE;
        endcase
        if (ctrl_wr_i) begin
            if (ctrl_wdata_i == '0)              state_nx = ST_IDLE;
            else if (ctrl_wdata_i[CTRL_ARM_BIT]) state_nx = ST_ARMED;
            else                                 state_nx = ST_WAIT_PACE;
        end
    end

    // outputs
    always_comb begin
        cnv_start_o   = (state_q == ST_WAIT_PACE) && pace_i && !ctrl_wr_i;
        done_accept_o = (state_q == ST_CONVERT) && cnv_done_i && !ctrl_wr_i;
        scan_last_o   = done_accept_o && (!scan_en_i || (pos_q == len_q));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            start_q <= '0;
            len_q   <= '0;
            pos_q   <= '0;
        end else if (ctrl_wr_i) begin
            start_q <= ctrl_wdata_i[SLOT_W-1:0];
            len_q   <= ctrl_wdata_i[CTRL_LEN_LSB +: SLOT_W];
            pos_q   <= '0;
        end else if (done_accept_o) begin
            pos_q <= scan_last_o ? '0 : pos_q + 1'b1;
        end
    end

    assign state_o = state_q;
    assign slot_o  = start_q + pos_q;

    a_r4_start_then_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnv_start_o |=> (state_q == ST_CONVERT));
    a_r6_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr_i && (ctrl_wdata_i == '0)) |=> (state_q == ST_IDLE) && (pos_q == '0));
    a_r5_armed_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ARMED && !ext_start_i && !ctrl_wr_i) |=> !cnv_start_o);
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              pace_i,
    input  logic              ext_start_i,
    output logic              cnv_start_o,
    output logic [3:0]        cnv_sel_o,
    output logic [1:0]        cnv_gain_o,
    output logic              cnv_unipolar_o,
    input  logic              cnv_done_i,
    input  logic [DATA_W-1:0] cnv_data_i,
    output logic              eos_o,
    output logic              irq_o
);
    seq_state_e        state;
    logic [SLOT_W-1:0] slot;
    slot_entry_t       cur_entry, new_entry;
    logic              done_accept, scan_last;
    logic              wr_ctrl, wr_mode, wr_entry, rd_pop, rd_stat, rd_flush;
    logic              scan_en_q, eos_ie_q, eoc_ie_q;
    logic              eoc_flag_q, eos_flag_q, eos_q;
    logic              fifo_full, fifo_empty;
    logic [DATA_W-1:0] fifo_dout, status;

    assign wr_ctrl  = bus_wr_i && (bus_addr_i == ADDR_DATA_CTRL);
    assign wr_mode  = bus_wr_i && (bus_addr_i == ADDR_STAT_MODE);
    assign wr_entry = bus_wr_i && (bus_addr_i == ADDR_ENTRY);
    assign rd_pop   = bus_rd_i && (bus_addr_i == ADDR_DATA_CTRL);
    assign rd_stat  = bus_rd_i && (bus_addr_i == ADDR_STAT_MODE);
    assign rd_flush = bus_rd_i && (bus_addr_i == ADDR_FLUSH);

    assign new_entry = '{unipolar: bus_wdata_i[7],
                         gain:     bus_wdata_i[5:4],
                         sel:      bus_wdata_i[3:0]};

    scan_chanlist #(.SLOTS(SLOT_COUNT)) i_chanlist (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_entry),
        .wr_idx_i   (bus_wdata_i[CTRL_LEN_LSB +: SLOT_W]),
        .wr_entry_i (new_entry),
        .rd_idx_i   (slot),
        .rd_entry_o (cur_entry)
    );

    scan_seq_fsm #(.CTRL_W(DATA_W)) i_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .ctrl_wr_i     (wr_ctrl),
        .ctrl_wdata_i  (bus_wdata_i),
        .scan_en_i     (scan_en_q),
        .pace_i        (pace_i),
        .ext_start_i   (ext_start_i),
        .cnv_done_i    (cnv_done_i),
        .state_o       (state),
        .slot_o        (slot),
        .cnv_start_o   (cnv_start_o),
        .done_accept_o (done_accept),
        .scan_last_o   (scan_last)
    );

    scan_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (done_accept),
        .pop_i   (rd_pop),
        .flush_i (rd_flush),
        .din_i   (cnv_data_i),
        .dout_o  (fifo_dout),
        .full_o  (fifo_full),
        .empty_o (fifo_empty)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scan_en_q  <= 1'b0;
            eos_ie_q   <= 1'b0;
            eoc_ie_q   <= 1'b0;
            eoc_flag_q <= 1'b0;
            eos_flag_q <= 1'b0;
            eos_q      <= 1'b0;
        end else begin
            if (wr_mode) begin
                scan_en_q <= bus_wdata_i[MODE_SCAN];
                eos_ie_q  <= bus_wdata_i[MODE_EOS_IE];
                eoc_ie_q  <= bus_wdata_i[MODE_EOC_IE];
            end
            // a new event wins over the clear-on-read
            if (done_accept)  eoc_flag_q <= 1'b1;
            else if (rd_stat) eoc_flag_q <= 1'b0;
            if (scan_last)    eos_flag_q <= 1'b1;
            else if (rd_stat) eos_flag_q <= 1'b0;
            eos_q <= scan_last;
        end
    end

    always_comb begin
        status     = '0;
        status[15] = (state == ST_CONVERT);
        status[14] = eoc_flag_q;
        status[13] = eos_flag_q;
        status[2]  = fifo_full;
        status[1]  = fifo_empty;
        unique case (bus_addr_i)
            ADDR_DATA_CTRL: bus_rdata_o = fifo_empty ? '0 : fifo_dout;
            ADDR_STAT_MODE: bus_rdata_o = status;
            default:        bus_rdata_o = '0;
        endcase
    end

    assign cnv_sel_o      = cur_entry.sel;
    assign cnv_gain_o     = cur_entry.gain;
    assign cnv_unipolar_o = cur_entry.unipolar;
    assign eos_o          = eos_q;
    assign irq_o          = (eoc_flag_q && eoc_ie_q) || (eos_flag_q && eos_ie_q);

    a_r8_eos_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eos_o |-> $past(cnv_done_i));
    a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stat && !cnv_done_i) |=> !eoc_flag_q && !eos_flag_q);
    a_r6_no_push_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_IDLE) |=> !eos_o);
endmodule

// File: tb/test_scan_sequencer.sv
module test_scan_sequencer;
    localparam int LAT = 3;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pace = 1'b0, ext_start = 1'b0;
    logic        cnv_start, cnv_uni, cnv_done = 1'b0;
    logic [3:0]  cnv_sel;
    logic [1:0]  cnv_gain;
    logic [15:0] cnv_data = '0;
    logic        eos, irq;

    int checks = 0, failures = 0;
    int starts_seen = 0, eos_seen = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    scan_sequencer i_scan_sequencer (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .pace_i(pace), .ext_start_i(ext_start), .cnv_start_o(cnv_start),
        .cnv_sel_o(cnv_sel), .cnv_gain_o(cnv_gain), .cnv_unipolar_o(cnv_uni),
        .cnv_done_i(cnv_done), .cnv_data_i(cnv_data), .eos_o(eos), .irq_o(irq));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // converter model: result three cycles after a start
    int cd = 0, conv_cnt = 0;
    logic [6:0] cap;
    always @(posedge clk) begin
        if (cnv_start) begin
            cd = LAT;
            cap = {cnv_uni, cnv_gain, cnv_sel};
            starts_seen++;
        end
        if (eos) eos_seen++;
    end
    always @(negedge clk) begin
        cnv_done <= 1'b0;
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                cnv_done <= 1'b1;
                cnv_data <= {conv_cnt[7:0], 1'b0, cap};
                conv_cnt++;
            end
        end
    end

    // behavioural reference model: 0 idle, 1 armed, 2 wait pace, 3 convert
    int m_state = 0, m_pos = 0, m_len = 0, m_start = 0;
    bit m_scan = 0, m_eosie = 0, m_eocie = 0;
    bit [6:0] m_list [16];
    int q[$];
    bit m_eocf = 0, m_eosf = 0, m_eos = 0;

    function automatic bit [15:0] m_status();
        return {m_state == 3, m_eocf, m_eosf, 10'b0, q.size() >= DEPTH, q.size() == 0, 1'b0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_pos = 0; m_len = 0; m_start = 0;
            m_scan = 0; m_eosie = 0; m_eocie = 0; q = {};
            m_eocf = 0; m_eosf = 0; m_eos = 0;
            foreach (m_list[i]) m_list[i] = '0;
        end else begin
            bit cw, acc, last, full_b, rstat;
            cw = bus_wr && bus_addr == 2'd0;
            rstat = bus_rd && bus_addr == 2'd1;
            acc = (m_state == 3) && cnv_done && !cw;
            last = acc && (!m_scan || m_pos == m_len);
            full_b = q.size() >= DEPTH;
            if (bus_rd && bus_addr == 2'd3) q = {};
            else begin
                if (bus_rd && bus_addr == 2'd0 && q.size() > 0) void'(q.pop_front());
                if (acc && !full_b) q.push_back(int'(cnv_data));
            end
            if (acc) m_eocf = 1; else if (rstat) m_eocf = 0;
            if (last) m_eosf = 1; else if (rstat) m_eosf = 0;
            m_eos = last;
            if (cw) begin
                m_pos = 0;
                m_start = bus_wdata[3:0];
                m_len = bus_wdata[11:8];
                m_state = (bus_wdata == 0) ? 0 : (bus_wdata[15] ? 1 : 2);
            end else begin
                if (acc) m_pos = last ? 0 : m_pos + 1;
                case (m_state)
                    1: if (ext_start) m_state = 2;
                    2: if (pace) m_state = 3;
                    3: if (cnv_done) m_state = 2;
                    default: ;
                endcase
            end
            if (bus_wr && bus_addr == 2'd1) begin
                m_scan = bus_wdata[3]; m_eosie = bus_wdata[1]; m_eocie = bus_wdata[0];
            end
            if (bus_wr && bus_addr == 2'd2) m_list[bus_wdata[11:8]] = {bus_wdata[7], bus_wdata[5:4], bus_wdata[3:0]};
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            bit [6:0] e;
            bit exp_start;
            bit [15:0] exp_rd;
            e = m_list[(m_start + m_pos) % 16];
            exp_start = (m_state == 2) && pace && !(bus_wr && bus_addr == 2'd0);
            check(cnv_start == exp_start, "R4 cnv_start", cnv_start, exp_start);
            check({cnv_uni, cnv_gain, cnv_sel} == e, "R1 R2 slot entry", {cnv_uni, cnv_gain, cnv_sel}, e);
            check(eos == m_eos, "R8 eos", eos, m_eos);
            check(irq == ((m_eocf && m_eocie) || (m_eosf && m_eosie)), "R10 irq", irq,
                  (m_eocf && m_eocie) || (m_eosf && m_eosie));
            if (bus_rd) begin
                exp_rd = (bus_addr == 2'd1) ? m_status() :
                         (bus_addr == 2'd0 && q.size() > 0) ? 16'(q[0]) : 16'h0;
                check(bus_rdata == exp_rd, "R7 R9 R11 rdata", bus_rdata, exp_rd);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask
    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a; #5 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask
    task automatic pace_once(input bit extra);
        @(negedge clk); pace = 1;
        @(negedge clk); pace = 0;
        if (extra) begin
            @(negedge clk); pace = 1;   // lands inside CONVERT: ignored (R4)
            @(negedge clk); pace = 0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        int s0, e0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12: reset state
        rd(2'd1, d);
        check(d == 16'h0002, "R12 reset status", d, 16'h0002);
        // R1: load all sixteen slots
        for (int i = 0; i < 16; i++)
            wr(2'd2, 16'((i << 8) | ((i & 1) << 7) | ((i % 4) << 4) | (15 - i)));
        wr(2'd1, 16'h000B);                 // scan on, both interrupts enabled
        wr(2'd0, 16'h030E);                 // R2: four slots from 14, wraps to 0,1
        for (int k = 0; k < 10; k++) pace_once(k % 2 == 0);
        check(starts_seen == 10, "R4 starts", starts_seen, 10);
        check(eos_seen == 2, "R2 R8 scans", eos_seen, 2);
        rd(2'd1, d);
        check(d == 16'h6004, "R9 status full with flags", d, 16'h6004);
        rd(2'd1, d);
        check(d == 16'h0004, "R9 flags cleared", d, 16'h0004);
        rd(2'd0, d);
        check(d == 16'h0021, "R1 R7 first sample slot 14", d, 16'h0021);
        for (int k = 0; k < 8; k++) rd(2'd0, d);
        check(d == 16'h0000, "R7 empty read", d, 0);
        // R3: single-entry mode, start slot 5
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h0305);
        e0 = eos_seen;
        for (int k = 0; k < 3; k++) pace_once(0);
        check(eos_seen - e0 == 3, "R3 every conversion ends scan", eos_seen - e0, 3);
        // R11: flush
        rd(2'd3, d);
        check(d == 16'h0000, "R11 flush reads zero", d, 0);
        rd(2'd1, d);
        check(d[2:1] == 2'b01, "R11 empty after flush", d[2:1], 1);
        // R5: armed start
        wr(2'd1, 16'h0001);
        wr(2'd0, 16'h8102);
        s0 = starts_seen;
        pace_once(0); pace_once(0);
        check(starts_seen == s0, "R5 pace ignored while armed", starts_seen - s0, 0);
        @(negedge clk); ext_start = 1;
        @(negedge clk); ext_start = 0;
        pace_once(0);
        check(starts_seen == s0 + 1, "R5 start after release", starts_seen - s0, 1);
        // R6: stop in the middle of a conversion
        @(negedge clk); pace = 1;
        @(negedge clk); pace = 0;
        wr(2'd0, 16'h0000);
        repeat (8) @(negedge clk);
        rd(2'd1, d);
        check((d & 16'h8006) == 16'h0000, "R6 idle with one stored sample", d & 16'h8006, 0);
        rd(2'd0, d);
        rd(2'd1, d);
        check(d[1] == 1'b1, "R6 stale result not stored", d[1], 1);
        pace_once(0);
        check(cnv_start == 1'b0, "R6 pace ignored when idle", cnv_start, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule